// File: doc/BRIEF.md
# Fully Associative Write-Back Byte Cache

This block is a small cache placed between a processor issuing single-byte loads and stores and a memory that moves whole 4-byte blocks. A 24-bit byte address splits into a 22-bit block tag (bits 23:2) and a 2-bit byte offset (bits 1:0). No address bits choose a line. Any block may sit in any line, and every valid line compares its stored tag with the incoming one in the same cycle.

Stores change only the cached copy and mark that line dirty. On a miss the controller first takes the lowest-numbered invalid line. Once every line is valid, it takes the line referenced least recently, using a recency list in which each completed access moves its line to the front. A dirty victim is written back to memory as one block before the new block is requested. A clean victim is overwritten without any memory write. A store miss allocates: the block is fetched, the store byte is merged into it, and the line is installed dirty. The controller walks through idle, lookup, writeback, fill and respond states. The number of lines is a parameter with a default of 8.

Top module: `assoc_wb_cache`

## Requirements
- R1: The tag is address bits 23:2 and the byte offset is bits 1:0. The memory request address is the 22-bit block tag, so a miss on byte address 0x16339C requests block 0x058CE7. Byte k of a block lies at bits 8k+7:8k.
- R2: Synchronous active-low reset leaves every line invalid and clean. After reset, cpu_req_ready is 1, and cpu_rsp_valid and mem_req_valid are 0.
- R3: A hit is detected by comparing all valid tags at once. A load hit returns the addressed byte with no memory request, and cpu_rsp_valid rises on the second clock edge after the request is accepted.
- R4: A store hit updates only the cache. It makes no memory request and sets the dirty bit of the line.
- R5: When all lines are valid, the victim of a miss is the line whose most recent completed access is the oldest.
- R6: While any line is invalid, a miss fills an invalid line, so the first LINES distinct blocks after reset cause no writeback.
- R7: A dirty victim is written to memory with mem_req_we=1, its own tag and its current contents, and this happens before the fill request for the new block. A clean victim causes no memory write.
- R8: A store miss fetches the block, merges the store byte into it, returns that byte, and leaves the line dirty. The block is therefore written back when it is later evicted.
- R9: Every load returns the most recently stored value of that byte, or the memory contents if the byte was never stored.
- R10: mem_req_valid, mem_req_we, mem_req_addr and mem_req_wdata stay unchanged until mem_req_ready is sampled high. A fill completes on the first mem_rsp_valid after its request has been accepted.
- R11: cpu_req_ready is high only in the idle state. Each accepted request produces exactly one single-cycle cpu_rsp_valid pulse, after which the cache is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache accepts a request this cycle |
| cpu_req_we | input | 1 | 1 = store byte, 0 = load byte |
| cpu_req_addr | input | 24 | Byte address |
| cpu_req_wdata | input | 8 | Store byte |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 8 | Byte value after the access |
| mem_req_valid | output | 1 | Memory block request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = block writeback, 0 = block fetch |
| mem_req_addr | output | 22 | Block address (tag) |
| mem_req_wdata | output | 32 | Writeback block data |
| mem_rsp_valid | input | 1 | Fetched block present |
| mem_rsp_rdata | input | 32 | Fetched block data |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the access history. No two lines may hit on the same tag. The recency list must remain a permutation, and a just-touched line must never be the next victim. A memory write may only come from a valid dirty line. Requests must be held stable until accepted. Responses must be single-cycle pulses, and a store must leave its line dirty. Victim choice in full detail, writeback-before-fill ordering, the exact written-back contents and data correctness after long mixes of hits, evictions and store misses depend on the access history. Only the bench's scenarios show these, by comparing against a byte-level reference memory and counting memory traffic per access.

// File: rtl/cache_pkg.sv
// Package: shared controller state encoding for the associative cache.
// Assumes: nothing beyond standard SystemVerilog.
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_WBACK  = 3'd2,
        ST_FILL   = 3'd3,
        ST_RESP   = 3'd4
    } ctrl_state_e;
endpackage

// File: rtl/cache_tag_match.sv
// Module: cache_tag_match
// Compares one lookup tag against every stored tag in parallel and reports
// the hitting line. It also reports the lowest-numbered invalid line.
// Assumes: the controller never installs a tag that is already resident,
// so at most one line can match.
module cache_tag_match #(
    parameter int LINES = 8,
    parameter int TAG_W = 22,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    input  logic [TAG_W-1:0] line_tag [LINES],
    input  logic [LINES-1:0] line_vld,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             has_free,
    output logic [IDX_W-1:0] free_idx
);
    logic [LINES-1:0] match;

    // One comparator per line, all evaluated in the same cycle.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_cmp
            assign match[g] = line_vld[g] && (line_tag[g] == look_tag);
        end
    endgenerate

    assign hit      = |match;
    assign has_free = ~&line_vld;

    // Encode the matching line into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    // Select the lowest-numbered invalid line (scan downward so the lowest wins).
    always_comb begin
        free_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!line_vld[i]) free_idx = IDX_W'(i);
        end
    end

    // R3: a tag is resident in at most one line.
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cache_lru_order.sv
// Module: cache_lru_order
// Holds the recency list of line indices. Slot 0 is the most recently used
// and the last slot is the replacement victim. A touch moves the line to
// slot 0 and shifts the lines ahead of it down by one slot.
// Assumes: LINES >= 2 and touch_idx < LINES.
module cache_lru_order #(
    parameter int LINES = 8,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] order [LINES];
    logic [IDX_W-1:0] pos;

    // Find the slot that currently holds the touched line.
    always_comb begin
        pos = IDX_W'(LINES - 1);
        for (int i = 0; i < LINES; i++) begin
            if (order[i] == touch_idx) pos = IDX_W'(i);
        end
    end

    // Move the touched line to the front and shift the younger slots down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) order[i] <= IDX_W'(i);
        end else if (touch_en) begin
            order[0] <= touch_idx;
            for (int i = 1; i < LINES; i++) begin
                if (IDX_W'(i) <= pos) order[i] <= order[i-1];
            end
        end
    end

    assign victim_idx = order[LINES-1];

    logic [LINES-1:0] seen;

    // Collect which line indices appear anywhere in the list.
    always_comb begin
        seen = '0;
        for (int i = 0; i < LINES; i++) seen = seen | (LINES'(1) << order[i]);
    end

    // R5: the list always holds every line exactly once.
    a_r5_order_perm: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

    // R5: a line just referenced is never the next victim.
    a_r5_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (victim_idx != $past(touch_idx)));
endmodule

// File: rtl/cache_line_store.sv
// Module: cache_line_store
// Storage for the cache lines: a valid bit, dirty bit, tag and data block
// per line. It has one byte-write port for store hits and one install port
// for fills.
// Assumes: the byte-write and install ports never target the same line in
// the same cycle.
module cache_line_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 22,
    parameter int OFF_W = 2,
    parameter int BLK_W = 8 << OFF_W,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [OFF_W-1:0] byte_off,
    input  logic [7:0]       byte_val,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [BLK_W-1:0] fill_data,
    input  logic             fill_dirty,
    output logic [TAG_W-1:0] line_tag  [LINES],
    output logic [BLK_W-1:0] line_data [LINES],
    output logic [LINES-1:0] line_vld,
    output logic [LINES-1:0] line_dirty
);
    // Valid and dirty bits: cleared by reset, set by installs and stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_vld   <= '0;
            line_dirty <= '0;
        end else begin
            if (fill_we) begin
                line_vld[fill_idx]   <= 1'b1;
                line_dirty[fill_idx] <= fill_dirty;
            end
            if (byte_we) line_dirty[byte_idx] <= 1'b1;
        end
    end

    // Tag and data payload: written by installs and byte stores, not reset.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            line_tag[fill_idx]  <= fill_tag;
            line_data[fill_idx] <= fill_data;
        end
        if (byte_we) line_data[byte_idx][{byte_off, 3'b000} +: 8] <= byte_val;
    end

    // R4: a stored byte leaves its line dirty.
    a_r4_store_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |=> line_dirty[$past(byte_idx)]);

    // R4: stores only land in resident lines.
    a_r4_store_valid_line: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |-> line_vld[byte_idx]);
endmodule

// File: rtl/assoc_wb_cache.sv
// Module: assoc_wb_cache (top)
// Fully associative write-back byte cache. It serves one byte request at a
// time. Misses fill an invalid line first, otherwise the least recently
// used line. A dirty victim is written back before the fetch. Store misses
// allocate.
// Assumes: the memory never raises mem_rsp_valid unless a fetch has been
// accepted, and this cache is the only writer of its cached blocks.
module assoc_wb_cache
    import cache_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int OFF_W  = 2,
    parameter  int LINES  = 8,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int BLK_W  = 8 << OFF_W,
    localparam int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [7:0]        cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [7:0]        cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [TAG_W-1:0]  mem_req_addr,
    output logic [BLK_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [BLK_W-1:0]  mem_rsp_rdata
);
    ctrl_state_e      state;
    logic             req_we;
    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    logic [7:0]       req_wdata;
    logic [IDX_W-1:0] cur_line;
    logic             fill_sent;

    logic [TAG_W-1:0] line_tag  [LINES];
    logic [BLK_W-1:0] line_data [LINES];
    logic [LINES-1:0] line_vld;
    logic [LINES-1:0] line_dirty;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             has_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] victim;
    logic             byte_we;
    logic             fill_we;
    logic [BLK_W-1:0] fill_data;
    logic             touch_en;

    cache_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_tag (req_tag),
        .line_tag (line_tag),
        .line_vld (line_vld),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .has_free (has_free),
        .free_idx (free_idx)
    );

    cache_lru_order #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (cur_line),
        .victim_idx (lru_idx)
    );

    cache_line_store #(.LINES(LINES), .TAG_W(TAG_W), .OFF_W(OFF_W),
                       .BLK_W(BLK_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (byte_we),
        .byte_idx   (hit_idx),
        .byte_off   (req_off),
        .byte_val   (req_wdata),
        .fill_we    (fill_we),
        .fill_idx   (cur_line),
        .fill_tag   (req_tag),
        .fill_data  (fill_data),
        .fill_dirty (req_we),
        .line_tag   (line_tag),
        .line_data  (line_data),
        .line_vld   (line_vld),
        .line_dirty (line_dirty)
    );

    // Victim choice: an invalid line if one exists, else the LRU line.
    assign victim = has_free ? free_idx : lru_idx;

    // Store hit writes its byte during lookup; a fill installs on the memory response.
    assign byte_we  = (state == ST_LOOKUP) && hit && req_we;
    assign fill_we  = (state == ST_FILL) && fill_sent && mem_rsp_valid;
    assign touch_en = (state == ST_RESP);

    // Merge a pending store byte into the fetched block.
    always_comb begin
        fill_data = mem_rsp_rdata;
        if (req_we) fill_data[{req_off, 3'b000} +: 8] = req_wdata;
    end

    // Port outputs decoded from the controller state.
    assign cpu_req_ready = (state == ST_IDLE);
    assign cpu_rsp_valid = (state == ST_RESP);
    assign cpu_rsp_rdata = line_data[cur_line][{req_off, 3'b000} +: 8];
    assign mem_req_valid = (state == ST_WBACK) || ((state == ST_FILL) && !fill_sent);
    assign mem_req_we    = (state == ST_WBACK);
    assign mem_req_addr  = (state == ST_WBACK) ? line_tag[cur_line] : req_tag;
    assign mem_req_wdata = line_data[cur_line];

    // Controller sequence: idle, lookup, optional writeback, fill, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_we    <= 1'b0;
            req_tag   <= '0;
            req_off   <= '0;
            req_wdata <= '0;
            cur_line  <= '0;
            fill_sent <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_req_valid) begin
                        req_we    <= cpu_req_we;
                        req_tag   <= cpu_req_addr[ADDR_W-1:OFF_W];
                        req_off   <= cpu_req_addr[OFF_W-1:0];
                        req_wdata <= cpu_req_wdata;
                        state     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    fill_sent <= 1'b0;
                    if (hit) begin
                        cur_line <= hit_idx;
                        state    <= ST_RESP;
                    end else begin
                        cur_line <= victim;
                        state    <= (line_vld[victim] && line_dirty[victim]) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (mem_req_ready) state <= ST_FILL;
                end
                ST_FILL: begin
                    if (!fill_sent && mem_req_ready) fill_sent <= 1'b1;
                    if (fill_sent && mem_rsp_valid) state <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a memory request holds its fields until accepted.
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)
             && $stable(mem_req_wdata)));

    // R7: memory writes come only from a valid dirty line.
    a_r7_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (line_vld[cur_line] && line_dirty[cur_line]));

    // R11: the cache is busy right after accepting a request.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R11: a response is a single-cycle pulse followed by readiness.
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> (!cpu_rsp_valid && cpu_req_ready));

    // R8: at a store response the line holds the requested block and is dirty.
    a_r8_store_resident_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && req_we) |->
            (line_vld[cur_line] && line_dirty[cur_line] && line_tag[cur_line] == req_tag));
endmodule

// File: tb/assoc_wb_cache_tb.sv
`timescale 1ns/1ps
module assoc_wb_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_we = 1'b0;
    logic [23:0] cpu_req_addr = '0;
    logic [7:0]  cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [7:0]  cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic [21:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cyc = 0;
    int fills = 0, wbs = 0;
    int fill_cyc = 0, wb_cyc = 0;
    logic [21:0] last_fill_addr = '0, last_wb_addr = '0;
    logic [31:0] last_wb_data = '0;

    logic [7:0]  gold    [logic [23:0]];
    logic [31:0] mem_blk [logic [21:0]];
    bit          rd_pend = 0;
    int          rd_wait = 0;
    logic [21:0] rd_tag = '0;

    always #4 clk = ~clk;

    assoc_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [7:0] init_byte(input logic [23:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] gold_byte(input logic [23:0] a);
        if (gold.exists(a)) return gold[a];
        return init_byte(a);
    endfunction

    function automatic logic [31:0] gold_block(input logic [21:0] t);
        logic [31:0] b;
        for (int k = 0; k < 4; k++) b[8*k +: 8] = gold_byte({t, 2'(k)});
        return b;
    endfunction

    function automatic logic [31:0] mem_read(input logic [21:0] t);
        logic [31:0] b;
        if (mem_blk.exists(t)) return mem_blk[t];
        for (int k = 0; k < 4; k++) b[8*k +: 8] = init_byte({t, 2'(k)});
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: decides ready and delivers fetches away from the active edge.
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rd_pend) begin
            if (rd_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem_read(rd_tag);
                rd_pend = 0;
            end else rd_wait--;
        end
        mem_req_ready = ($urandom_range(0, 3) != 0);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem_blk[mem_req_addr] = mem_req_wdata;
                wbs++;
                wb_cyc = cyc;
                last_wb_addr = mem_req_addr;
                last_wb_data = mem_req_wdata;
                // R7: written-back block equals the latest contents of that block.
                chk(mem_req_wdata == gold_block(mem_req_addr), "R7", "writeback data",
                    mem_req_wdata, gold_block(mem_req_addr));
            end else begin
                fills++;
                fill_cyc = cyc;
                last_fill_addr = mem_req_addr;
                rd_pend = 1;
                rd_wait = $urandom_range(0, 2);
                rd_tag = mem_req_addr;
            end
        end
    end

    task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d,
                          output logic [7:0] r, output int lat);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        lat = 1;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        r = cpu_rsp_rdata;
        if (we) gold[a] = d;
    endtask

    task automatic rd(input logic [23:0] a, input string req);
        logic [7:0] r;
        int lat;
        access(1'b0, a, 8'h00, r, lat);
        chk(r == gold_byte(a), req, "load data", {24'h0, r}, {24'h0, gold_byte(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int lat, f0, w0;
        void'($urandom(32'h1234_5678));
        repeat (5) @(negedge clk);
        // R2: reset state at the ports.
        chk(cpu_req_ready == 1'b1, "R2", "ready in reset", {31'h0, cpu_req_ready}, 32'h1);
        chk(cpu_rsp_valid == 1'b0, "R2", "rsp_valid in reset", {31'h0, cpu_rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R2", "mem_req_valid in reset", {31'h0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: the tag of 0x16339C is the block address of the fill.
        f0 = fills;
        access(1'b0, 24'h16339C, 8'h00, r, lat);
        chk(fills == f0 + 1, "R1", "one fill", fills - f0, 1);
        chk(last_fill_addr == 22'h058CE7, "R1", "fill address", {10'h0, last_fill_addr}, 32'h058CE7);
        chk(r == gold_byte(24'h16339C), "R9", "miss data", {24'h0, r}, {24'h0, gold_byte(24'h16339C)});

        // R3: a load hit in the same block has no traffic and a 2-edge latency.
        f0 = fills; w0 = wbs;
        access(1'b0, 24'h16339E, 8'h00, r, lat);
        chk(fills == f0 && wbs == w0, "R3", "hit traffic", fills - f0 + wbs - w0, 0);
        chk(lat == 2, "R3", "hit latency", lat, 2);
        chk(r == gold_byte(24'h16339E), "R3", "hit data", {24'h0, r}, {24'h0, gold_byte(24'h16339E)});

        // R4: a store hit stays in the cache.
        access(1'b1, 24'h16339D, 8'hA5, r, lat);
        chk(fills == f0 && wbs == w0, "R4", "store hit traffic", fills - f0 + wbs - w0, 0);
        rd(24'h16339D, "R4");

        // R6: seven more blocks fill the remaining invalid lines with no writeback.
        w0 = wbs;
        for (int i = 1; i <= 7; i++) rd({22'(i), 2'b00}, "R6");
        chk(wbs == w0, "R6", "no writeback while lines free", wbs - w0, 0);

        // R5, R7: a ninth block evicts the dirty LRU block, writeback before fill.
        w0 = wbs;
        rd({22'd8, 2'b00}, "R5");
        chk(wbs == w0 + 1, "R7", "dirty victim written", wbs - w0, 1);
        chk(last_wb_addr == 22'h058CE7, "R5", "victim is LRU", {10'h0, last_wb_addr}, 32'h058CE7);
        chk(last_wb_data[15:8] == 8'hA5, "R7", "stored byte written back", {24'h0, last_wb_data[15:8]}, 32'hA5);
        chk(wb_cyc < fill_cyc, "R7", "writeback before fill", wb_cyc, fill_cyc);

        // R5: touch block 1, so block 2 becomes the (clean) victim.
        f0 = fills;
        rd({22'd1, 2'b00}, "R5");
        chk(fills == f0, "R5", "block 1 resident", fills - f0, 0);
        w0 = wbs;
        rd({22'd9, 2'b00}, "R5");
        chk(wbs == w0, "R7", "clean victim not written", wbs - w0, 0);
        f0 = fills;
        rd({22'd1, 2'b01}, "R5");
        chk(fills == f0, "R5", "recent block kept", fills - f0, 0);
        rd({22'd2, 2'b00}, "R5");
        chk(fills == f0 + 1, "R5", "LRU block was evicted", fills - f0, 1);

        // R8: a store miss allocates, merges and stays dirty until evicted.
        f0 = fills; w0 = wbs;
        access(1'b1, {22'd10, 2'b11}, 8'h3C, r, lat);
        chk(fills == f0 + 1, "R8", "store miss fetch", fills - f0, 1);
        chk(r == 8'h3C, "R8", "store miss response", {24'h0, r}, 32'h3C);
        rd({22'd10, 2'b00}, "R8");
        w0 = wbs;
        for (int i = 20; i < 28; i++) rd({22'(i), 2'b00}, "R8");
        chk(wbs == w0 + 1, "R8", "allocated block written back once", wbs - w0, 1);
        chk(last_wb_addr == 22'd10, "R8", "writeback tag", {10'h0, last_wb_addr}, 32'd10);

        // R9, R10: random mix over 12 blocks with random memory stalls.
        for (int n = 0; n < 400; n++) begin
            logic [23:0] a;
            logic [7:0]  d;
            bit          we;
            a  = {22'(32'h100 + $urandom_range(0, 11)), 2'($urandom_range(0, 3))};
            d  = 8'($urandom);
            we = ($urandom_range(0, 9) < 4);
            access(we, a, d, r, lat);
            chk(r == gold_byte(a), "R9", "random access data", {24'h0, r}, {24'h0, gold_byte(a)});
        end

        // R11: cache is ready again after the last response.
        @(negedge clk);
        chk(cpu_req_ready == 1'b1 && cpu_rsp_valid == 1'b0, "R11", "idle after response",
            {31'h0, cpu_req_ready}, 32'h1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule